// File: doc/BRIEF.md
# Error-Rate Hysteresis Mute Detector

This block watches the double-error flags raised by a (63,56) BCH decoder and decides whether the audio path should be muted because the channel is too noisy. It counts flag pulses over a window of frames, and the window length can be selected. When a window closes, the count is compared with a threshold. The threshold is a power-of-two fraction of the largest count the window can hold, which is 32 flags per frame times the window length. A count above the threshold sets the mute. Only a later window whose count falls below half of that threshold clears it. This gap between the set point and the clear point stops the output from chattering near the limit.

The block is controlled by a 2-bit window code, a 2-bit threshold code and a disable input. A change to either code restarts the window from frame zero and throws away the partial count. The decision lives in a two-state machine. `ST_PASS` goes to `ST_MUTE` on the transition *trip*: a window closes with a count above the set threshold. `ST_MUTE` goes back to `ST_PASS` on the transition *recover*: a window closes with a count below the clear threshold. Every other cycle is *hold*, and the state does not change.

Top module: `errmute_top`

## Requirements
- R1: While `rst_n` is low, `mute_o` is low. The first window after reset starts at frame zero with a count of zero.
- R2: The window is `BASE_FRAMES << win_sel` frame strobes long. The codes 00, 01, 10 and 11 give 128, 256, 512 and 1024 frames at the default base. The mute state can change only on the clock edge of the frame strobe that completes a window. At all other times it holds.
- R3: The count for a window is the number of cycles in which `dbl_err` is high, from the cycle after the previous window closed up to and including the cycle of the closing strobe. At most one flag is counted per cycle.
- R4: The window maximum is `MAX_ERR_PER_FRAME` times the window length. The set threshold is that maximum shifted right by `thr_sel + 1`, so the codes 00, 01, 10 and 11 give 1/2, 1/4, 1/8 and 1/16 of it. In `ST_PASS`, a closing count strictly greater than the set threshold moves the state to `ST_MUTE`. A count equal to the threshold does not.
- R5: The clear threshold is half of the set threshold. In `ST_MUTE`, a closing count strictly less than the clear threshold returns the state to `ST_PASS`. A count equal to or above it keeps the mute.
- R6: While `mute_dis` is high, `mute_o` is low. The state machine still takes its decisions, and `mute_o` follows the state again as soon as `mute_dis` is low.
- R7: When `win_sel` or `thr_sel` differs from the value held on the previous clock, the frame position and the count both go back to zero. Any strobe or flag in that cycle is ignored. The mute state is kept.
- R8: The count saturates at the window maximum and does not wrap. A window that receives more flags than the counter width can hold still closes with the maximum count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb | input | 1 | One-cycle pulse marking the end of a frame |
| dbl_err | input | 1 | One-cycle pulse per double-error flag from the decoder |
| win_sel | input | 2 | Window length code |
| thr_sel | input | 2 | Threshold fraction code |
| mute_dis | input | 1 | Suppresses the mute output when high |
| mute_o | output | 1 | Mute request |

## Verification
The hardest situation to reach from the ports is a count that overflows the counter register. No legal frame can produce it, because the window maximum is well below the register's capacity. The bench sends more than 2048 flags into a single four-frame window with a reduced base length, so a wrapping counter would close far below the set threshold and show a clear window. The restart on a code change is also hard to observe. The bench switches the window code mid-window, after a partial count that would trip the mute if it were carried over. It then checks that the new, longer window closes at its own length with only its own flags counted.

// File: rtl/errmute_pkg.sv
package errmute_pkg;

    typedef enum logic [0:0] {
        ST_PASS = 1'b0,
        ST_MUTE = 1'b1
    } mute_st_e;

    typedef struct packed {
        logic [1:0] win;
        logic [1:0] thr;
    } mute_cfg_t;

endpackage

// File: rtl/errmute_window.sv
module errmute_window #(
    parameter int BASE_FRAMES = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       frame_stb,
    input  logic [1:0] win_sel,
    output logic       win_end
);
    localparam int FW = $clog2(BASE_FRAMES * 8);

    logic [FW-1:0] frm_q;
    logic [FW:0]   win_len;
    logic          at_last;

    assign win_len = (FW+1)'(BASE_FRAMES) << win_sel;
    assign at_last = ({1'b0, frm_q} == (win_len - 1'b1));
    assign win_end = frame_stb && !restart && at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q <= '0;
        end else if (restart) begin
            frm_q <= '0;
        end else if (frame_stb) begin
            frm_q <= at_last ? '0 : frm_q + 1'b1;
        end
    end

    // R2: the frame position never reaches the selected window length
    a_r2_frame_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> ({1'b0, frm_q} < win_len));

    // R7: a restart returns the frame position to zero
    a_r7_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (frm_q == '0));

endmodule

// File: rtl/errmute_errcnt.sv
module errmute_errcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             dbl_err,
    input  logic             win_end,
    input  logic [CNT_W-1:0] cnt_max,
    output logic [CNT_W-1:0] cnt_eff
);
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        if (dbl_err && !restart && (cnt_q < cnt_max)) begin
            cnt_eff = cnt_q + 1'b1;
        end else begin
            cnt_eff = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || win_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_eff;
        end
    end

    // R8: the stored count never passes the window maximum
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> (cnt_q <= cnt_max));

    // R7: a restart discards the partial count
    a_r7_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

    // R3: outside window closure and restart the count never decreases
    a_r3_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !win_end) |=> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/errmute_thresh.sv
module errmute_thresh #(
    parameter int BASE_FRAMES       = 128,
    parameter int MAX_ERR_PER_FRAME = 32,
    parameter int CNT_W             = 16
) (
    input  logic [1:0]       win_sel,
    input  logic [1:0]       thr_sel,
    output logic [CNT_W-1:0] cnt_max,
    output logic [CNT_W-1:0] thr_set,
    output logic [CNT_W-1:0] thr_clr
);
    localparam int BASE_MAX = MAX_ERR_PER_FRAME * BASE_FRAMES;

    logic [2:0] set_sh;
    logic [2:0] clr_sh;

    assign set_sh  = 3'(thr_sel) + 3'd1;
    assign clr_sh  = 3'(thr_sel) + 3'd2;
    assign cnt_max = CNT_W'(BASE_MAX) << win_sel;
    assign thr_set = cnt_max >> set_sh;
    assign thr_clr = cnt_max >> clr_sh;

endmodule

// File: rtl/errmute_top.sv
module errmute_top
    import errmute_pkg::*;
#(
    parameter int BASE_FRAMES       = 128,
    parameter int MAX_ERR_PER_FRAME = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_stb,
    input  logic       dbl_err,
    input  logic [1:0] win_sel,
    input  logic [1:0] thr_sel,
    input  logic       mute_dis,
    output logic       mute_o
);
    localparam int MAX_SPAN = BASE_FRAMES * 8;
    localparam int CNT_W    = $clog2(MAX_ERR_PER_FRAME * MAX_SPAN) + 1;

    mute_cfg_t        cfg_now;
    mute_cfg_t        cfg_q;
    logic             restart;
    logic             win_end;
    logic [CNT_W-1:0] cnt_eff;
    logic [CNT_W-1:0] cnt_max;
    logic [CNT_W-1:0] thr_set;
    logic [CNT_W-1:0] thr_clr;
    mute_st_e         st_q;
    mute_st_e         st_d;

    assign cfg_now.win = win_sel;
    assign cfg_now.thr = thr_sel;
    assign restart     = (cfg_now != cfg_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_now;
        end
    end

    errmute_window #(
        .BASE_FRAMES (BASE_FRAMES)
    ) win_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .frame_stb (frame_stb),
        .win_sel   (win_sel),
        .win_end   (win_end)
    );

    errmute_thresh #(
        .BASE_FRAMES       (BASE_FRAMES),
        .MAX_ERR_PER_FRAME (MAX_ERR_PER_FRAME),
        .CNT_W             (CNT_W)
    ) thr_i (
        .win_sel (win_sel),
        .thr_sel (thr_sel),
        .cnt_max (cnt_max),
        .thr_set (thr_set),
        .thr_clr (thr_clr)
    );

    errmute_errcnt #(
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .dbl_err (dbl_err),
        .win_end (win_end),
        .cnt_max (cnt_max),
        .cnt_eff (cnt_eff)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_PASS;
        end else begin
            st_q <= st_d;
        end
    end

    // next state: trip, recover or hold
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_PASS: if (win_end && (cnt_eff > thr_set)) st_d = ST_MUTE;
            ST_MUTE: if (win_end && (cnt_eff < thr_clr)) st_d = ST_PASS;
            default: st_d = ST_PASS;
        endcase
    end

    // output
    always_comb begin
        mute_o = (st_q == ST_MUTE) && !mute_dis;
    end

    // R2: state holds except on a window-closing edge
    a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(st_q));

    // R4: a closing count above the set threshold trips the mute
    a_r4_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PASS && win_end && cnt_eff > thr_set) |=> (st_q == ST_MUTE));

    // R5: a closing count below the clear threshold recovers
    a_r5_recover: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_MUTE && win_end && cnt_eff < thr_clr) |=> (st_q == ST_PASS));

    // R5: the clear point lies strictly below the set point
    a_r5_gap: assert property (@(posedge clk) disable iff (!rst_n)
        thr_clr < thr_set);

    // R7: a restart leaves the mute state unchanged
    a_r7_keep_state: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> $stable(st_q));

endmodule

// File: tb/errmute_top_tb_top.sv
`timescale 1ns/1ps
module errmute_top_tb_top;
    localparam int BASE = 4;
    localparam int PERF = 32;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       frame_stb;
    logic       dbl_err;
    logic [1:0] win_sel;
    logic [1:0] thr_sel;
    logic       mute_dis;
    logic       mute_o;

    int checks = 0;
    int errors = 0;
    bit model_st = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    errmute_top #(
        .BASE_FRAMES       (BASE),
        .MAX_ERR_PER_FRAME (PERF)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .dbl_err   (dbl_err),
        .win_sel   (win_sel),
        .thr_sel   (thr_sel),
        .mute_dis  (mute_dis),
        .mute_o    (mute_o)
    );

    task automatic check(input string tag, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: mute_o=%0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit stb, input bit err);
        frame_stb = stb;
        dbl_err   = err;
        @(negedge clk);
        frame_stb = 1'b0;
        dbl_err   = 1'b0;
    endtask

    function automatic int wlen(input int w);
        return BASE << w;
    endfunction

    function automatic int aset(input int w, input int t);
        return ((PERF * BASE) << w) >> (t + 1);
    endfunction

    task automatic set_cfg(input int w, input int t);
        win_sel = 2'(w);
        thr_sel = 2'(t);
        @(negedge clk);
        @(negedge clk);
    endtask

    // n flags spread over the window; coin puts the last flag on the closing strobe
    task automatic run_window(input int n, input bit coin, input string tag);
        int w   = int'(win_sel);
        int t   = int'(thr_sel);
        int W   = wlen(w);
        int a   = aset(w, t);
        int r   = a / 2;
        int rem = n - (coin ? 1 : 0);
        bit nxt;
        for (int f = 0; f < W; f++) begin
            int k = (f == W - 1) ? rem : ((rem > PERF) ? PERF : rem);
            for (int i = 0; i < k; i++) cyc(1'b0, 1'b1);
            rem -= k;
            if (f == W - 1) begin
                // R2: no change before the closing strobe
                check("R2 hold before window end", mute_o, model_st & ~mute_dis);
                cyc(1'b1, coin);
            end else begin
                cyc(1'b1, 1'b0);
            end
        end
        nxt = model_st;
        if (!model_st && n > a) nxt = 1'b1;
        if (model_st && n < r) nxt = 1'b0;
        model_st = nxt;
        check(tag, mute_o, model_st & ~mute_dis);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: mute_o=%0b expected finish", mute_o);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; frame_stb = 1'b0; dbl_err = 1'b0;
        win_sel = 2'd0; thr_sel = 2'd0; mute_dis = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset state", mute_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", mute_o, 1'b0);

        // sweep every window and threshold code
        for (int w = 0; w < 4; w++) begin
            for (int t = 0; t < 4; t++) begin
                int a = aset(w, t);
                int r = a / 2;
                set_cfg(w, t);
                run_window(0, 1'b0, "R5 clean window");
                run_window(a, 1'b0, "R4 equal to set point");
                run_window(a + 1, (w == t), "R4 above set point");
                run_window(r, 1'b0, "R5 equal to clear point");
                run_window(r - 1, 1'b0, "R5 below clear point");
            end
        end

        // R3: closing flag on the strobe is counted
        set_cfg(0, 0);
        run_window(0, 1'b0, "R3 clean");
        run_window(aset(0, 0) + 1, 1'b1, "R3 flag with strobe");
        run_window(0, 1'b0, "R3 recover");

        // R6: disable hides the mute, decisions continue
        mute_dis = 1'b1;
        run_window(aset(0, 0) + 1, 1'b0, "R6 disabled trips silently");
        check("R6 output low while disabled", mute_o, 1'b0);
        mute_dis = 1'b0;
        @(negedge clk);
        check("R6 output returns", mute_o, 1'b1);
        run_window(0, 1'b0, "R6 recover");

        // R7: partial count dropped on code change, state kept
        set_cfg(0, 0);
        for (int i = 0; i < 32; i++) cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b0);
        for (int i = 0; i < 33; i++) cyc(1'b0, 1'b1);
        cyc(1'b1, 1'b0);
        set_cfg(1, 0);
        run_window(100, 1'b0, "R7 restart discards partial");
        run_window(aset(1, 0) + 1, 1'b0, "R7 trip");
        set_cfg(2, 1);
        check("R7 state kept on change", mute_o, 1'b1);
        run_window(0, 1'b0, "R7 recover after change");

        // R8: overflow saturates
        set_cfg(0, 0);
        run_window(2100, 1'b0, "R8 saturated count trips");
        run_window(0, 1'b0, "R8 recover");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule